// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the target side of a two-wire serial bus, reduced to a byte engine that firmware steers. The block follows SCL and SDA through a short synchronizer and detects START and STOP. After a START it compares the first byte with a programmable 7-bit address. Once addressed, it moves one shift register through the bus, MSB first. A bit counter raises an interrupt either at the end of every byte or after each single bit. Bit-wise mode is meant for the acknowledge slot. When the interrupt fires, the engine can pull SCL low and keep it low until firmware writes the data register.

Firmware drives each exchange through writes to the data register. The MSB of the value written is the next level the engine puts on SDA. Writing 0x7F in single-bit mode acknowledges a byte. Writing all ones lets go of SDA, so the engine can sample a byte or the controller's ACK/NACK. Both bus lines are open-drain: the block only reports that it wants a line low.

The control path is a four-state machine:
- IDLE: no transfer.
- ADDR: the address byte is arriving.
- ACTIVE: this target is selected.
- SKIP: another target was addressed.

Its transitions are:
- Any state to ADDR on START.
- Any state to IDLE on STOP.
- ADDR to ACTIVE on the eighth rising SCL edge when the address matches.
- ADDR to SKIP on the eighth rising SCL edge when it does not.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset both pull outputs are 0, `irq` is 0, `ack_nack` is 0 and `rd_data` reads 0xFF.
- R2: After START, bits 7..1 of the first byte (MSB first; bit 0 is the direction) are compared with `own_addr`. A match raises `irq` on the eighth bit whatever `count_single` says. A mismatch gives no interrupt and no pull on either line until the next START.
- R3: With `count_single`=0, `irq` rises after eight SCL rising edges counted from the previous interrupt point. `rd_data` then holds the byte sampled MSB first.
- R4: With `count_single`=1 in the selected state, `irq` rises on every SCL rising edge, which includes the ninth (ACK/NACK) bit.
- R5: When `irq` fires with `stretch_off`=0, `scl_pull` goes to 1 once SCL is low. It stays 1 until a data write.
- R6: A write (`wr_en`=1) clears `irq` and releases a stretch. Bit 7 of the written value decides SDA for the current or next low phase (0 pulls low). Writing 0xFF lets the controller's level be seen.
- R7: With `stretch_off`=1, interrupts still fire but `scl_pull` stays 0, and the transfer goes on without firmware.
- R8: A written byte is shifted out MSB first, one bit per SCL low phase. `sda_pull` never changes while SCL stays high.
- R9: After an interrupt point, SDA is released until firmware writes.
- R10: `ack_nack` takes the SDA level on the ninth rising edge of every frame (0 = ACK, 1 = NACK).
- R11: START clears `irq` and any pending stretch and re-enters ADDR. STOP clears `irq` and returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Address this target answers to |
| stretch_off | input | 1 | 1 disables clock stretching |
| count_single | input | 1 | 0: interrupt per byte, 1: interrupt per bit |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Value written to the data register |
| rd_data | output | 8 | Current data register (received bits) |
| irq | output | 1 | Counter interrupt, level |
| ack_nack | output | 1 | Level sampled on the ninth bit of the last frame |

## Verification
The bench uses the default parameters: a 7-bit address, 8-bit data and a two-stage synchronizer. With these, a bus edge reaches the state machine three clocks after it appears. A 16-clock half period of the modelled controller therefore places every sample well clear of the synchronizer delay. It also lets a START be inserted within a single SCL high phase, just after the address's eighth edge, which shows that a stretch armed in that phase is cancelled. A full 8-bit byte followed by a one-bit ACK interval can be stepped through bit by bit, with firmware writes placed while the clock is stretched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACTIVE,
        ST_SKIP
    } link_state_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_prev;
    logic             sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_in};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_in};
            scl_prev <= scl_pipe[DEPTH-1];
            sda_prev <= sda_pipe[DEPTH-1];
        end
    end

    assign scl_lvl   = scl_pipe[DEPTH-1];
    assign sda_lvl   = sda_pipe[DEPTH-1];
    assign scl_rise  = scl_lvl && !scl_prev;
    assign scl_fall  = !scl_lvl && scl_prev;
    assign start_evt = scl_lvl && scl_prev && sda_prev && !sda_lvl;
    assign stop_evt  = scl_lvl && scl_prev && !sda_prev && sda_lvl;

endmodule

// File: rtl/i2cs_bit_counter.sv
module i2cs_bit_counter #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic single,
    output logic hit
);

    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST_FULL = CW'(DATA_W - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = single ? '0 : LAST_FULL;
    assign hit  = tick && !clear && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the count never passes the byte length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(DATA_W));

endmodule

// File: rtl/i2cs_link_ctrl.sv
module i2cs_link_ctrl
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              cnt_hit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_off,
    input  logic              count_single,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cnt_tick,
    output logic              cnt_clear,
    output logic              cnt_single,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              irq,
    output logic              ack_nack,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PW = $clog2(DATA_W + 2);
    localparam logic [PW-1:0] ACK_SLOT = PW'(DATA_W);

    link_state_t       state;
    link_state_t       state_nx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rx_byte;
    logic              addr_match;
    logic              point;
    logic              out_bit;
    logic              await_wr;
    logic              stretch_pend;
    logic [PW-1:0]     frame_pos;
    logic              bus_evt;

    assign bus_evt    = start_evt || stop_evt;
    assign rx_byte    = {shreg[DATA_W-2:0], sda_lvl};
    assign addr_match = (rx_byte[DATA_W-1 -: ADDR_W] == own_addr);
    assign cnt_tick   = scl_rise && ((state == ST_ADDR) || (state == ST_ACTIVE));
    assign cnt_clear  = bus_evt;
    assign cnt_single = count_single && (state == ST_ACTIVE);
    assign point      = cnt_hit && (((state == ST_ADDR) && addr_match) || (state == ST_ACTIVE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transition logic
    always_comb begin
        state_nx = state;
        if (start_evt) begin
            state_nx = ST_ADDR;
        end else if (stop_evt) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_ADDR:   if (cnt_hit) state_nx = addr_match ? ST_ACTIVE : ST_SKIP;
                ST_ACTIVE: state_nx = ST_ACTIVE;
                ST_SKIP:   state_nx = ST_SKIP;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg        <= '1;
            out_bit      <= 1'b1;
            await_wr     <= 1'b0;
            irq          <= 1'b0;
            stretch_pend <= 1'b0;
            scl_pull     <= 1'b0;
            frame_pos    <= '0;
            ack_nack     <= 1'b0;
        end else if (bus_evt) begin
            shreg        <= '1;
            out_bit      <= 1'b1;
            await_wr     <= 1'b0;
            irq          <= 1'b0;
            stretch_pend <= 1'b0;
            scl_pull     <= 1'b0;
            frame_pos    <= '0;
        end else begin
            if (wr_en) begin
                shreg <= wr_data;
            end else if (cnt_tick) begin
                shreg <= rx_byte;
            end

            if (state != ST_ACTIVE) begin
                out_bit <= 1'b1;
            end else if (wr_en && !scl_lvl) begin
                out_bit <= wr_data[DATA_W-1];
            end else if (scl_fall) begin
                out_bit <= await_wr ? 1'b1 : shreg[DATA_W-1];
            end

            if (wr_en) begin
                await_wr <= 1'b0;
            end else if (point) begin
                await_wr <= 1'b1;
            end

            if (point) begin
                irq <= 1'b1;
            end else if (wr_en) begin
                irq <= 1'b0;
            end

            if (point && !stretch_off) begin
                stretch_pend <= 1'b1;
            end else if (wr_en) begin
                stretch_pend <= 1'b0;
            end

            if (wr_en) begin
                scl_pull <= 1'b0;
            end else begin
                scl_pull <= stretch_pend && !scl_lvl;
            end

            if (cnt_tick) begin
                if (frame_pos == ACK_SLOT) begin
                    ack_nack  <= sda_lvl;
                    frame_pos <= '0;
                end else begin
                    frame_pos <= frame_pos + 1'b1;
                end
            end
        end
    end

    assign sda_pull = (state == ST_ACTIVE) && !out_bit;
    assign rd_data  = shreg;

    // R8: data line stays put through a steady clock-high phase
    p_sda_quiet_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(bus_evt)) |-> $stable(sda_pull));

    // R6: a stretch ends only through a write or a bus condition
    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull) |-> $past(wr_en || bus_evt));

    // R6: a write clears the interrupt unless a new point arrives
    p_irq_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(point) && !$past(bus_evt)) |-> !irq);

    // R7: no stretch is armed while stretching is disabled
    p_no_arm_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_pend) |-> !$past(stretch_off));

    // R11: a START leaves neither interrupt nor stretch behind
    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (!irq && !scl_pull && !stretch_pend));

    // R2: an unaddressed target is silent
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_pull && !scl_pull && !irq));

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_off,
    input  logic              count_single,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              ack_nack
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic cnt_tick, cnt_clear, cnt_single, cnt_hit;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cs_bit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .tick   (cnt_tick),
        .single (cnt_single),
        .hit    (cnt_hit)
    );

    i2cs_link_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (scl_lvl),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .cnt_hit      (cnt_hit),
        .own_addr     (own_addr),
        .stretch_off  (stretch_off),
        .count_single (count_single),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cnt_tick     (cnt_tick),
        .cnt_clear    (cnt_clear),
        .cnt_single   (cnt_single),
        .scl_pull     (scl_pull),
        .sda_pull     (sda_pull),
        .irq          (irq),
        .ack_nack     (ack_nack),
        .rd_data      (rd_data)
    );

endmodule

// File: tb/sim_i2c_stretch_slave.sv
`timescale 1ns/100ps
module sim_i2c_stretch_slave;

    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [6:0] own_addr = 7'h5A;
    logic       stretch_off = 1'b0;
    logic       count_single = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scl_pull, sda_pull, irq, ack_nack;
    logic [7:0] rd_data;
    logic       scl_bus, sda_bus;
    int         n_vec = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    assign scl_bus = m_scl & ~scl_pull;
    assign sda_bus = m_sda & ~sda_pull;

    i2c_stretch_slave u0 (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_bus), .sda_in (sda_bus),
        .scl_pull (scl_pull), .sda_pull (sda_pull), .own_addr (own_addr),
        .stretch_off (stretch_off), .count_single (count_single),
        .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
        .irq (irq), .ack_nack (ack_nack)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(posedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; idle(H);
        m_scl = 1'b0; idle(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; idle(H);
        m_scl = 1'b1; wait_scl_high(); idle(H);
        m_sda = 1'b1; idle(H);
    endtask

    task automatic put_bit(input logic b, output logic got);
        m_sda = b; idle(H);
        m_scl = 1'b1; wait_scl_high(); idle(H);
        @(negedge clk) got = sda_bus;
        m_scl = 1'b0; idle(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic g;
            put_bit(v[i], g);
            got[i] = g;
        end
    endtask

    task automatic fw_write(input logic [7:0] v);
        @(negedge clk) begin wr_data = v; wr_en = 1'b1; end
        @(negedge clk) wr_en = 1'b0;
        idle(4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 scl_pull", {7'd0, scl_pull}, 8'd0);
        chk("R1 sda_pull", {7'd0, sda_pull}, 8'd0);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 ack_nack", {7'd0, ack_nack}, 8'd0);
        chk("R1 rd_data", rd_data, 8'hFF);
    endtask

    task automatic t_write_to_slave();
        logic [7:0] got;
        logic g;
        bus_start();
        send_byte(8'hB4, got);
        @(negedge clk);
        chk("R2 irq on address match", {7'd0, irq}, 8'd1);
        chk("R3 address byte in rd_data", rd_data, 8'hB4);
        chk("R5 scl held", {7'd0, scl_pull}, 8'd1);
        idle(40); @(negedge clk);
        chk("R5 scl still held", {7'd0, scl_bus}, 8'd0);
        count_single = 1'b1;
        fw_write(8'h7F);
        @(negedge clk);
        chk("R6 irq cleared by write", {7'd0, irq}, 8'd0);
        chk("R6 stretch released", {7'd0, scl_pull}, 8'd0);
        put_bit(1'b1, g);
        chk("R6 slave ack driven", {7'd0, g}, 8'd0);
        @(negedge clk);
        chk("R4 irq on ack bit", {7'd0, irq}, 8'd1);
        chk("R10 ack sampled", {7'd0, ack_nack}, 8'd0);
        count_single = 1'b0;
        fw_write(8'hFF);
        send_byte(8'h3C, got);
        chk("R6 released sda carries master data", got, 8'h3C);
        @(negedge clk);
        chk("R3 irq after data byte", {7'd0, irq}, 8'd1);
        chk("R3 data byte received", rd_data, 8'h3C);
        count_single = 1'b1;
        fw_write(8'h7F);
        put_bit(1'b1, g);
        chk("R6 data ack driven", {7'd0, g}, 8'd0);
        count_single = 1'b0;
        fw_write(8'hFF);
        bus_stop();
        @(negedge clk);
        chk("R11 idle after stop", {6'd0, scl_pull, sda_pull}, 8'd0);
    endtask

    task automatic t_mismatch();
        logic [7:0] got;
        logic g;
        bus_start();
        send_byte({7'h11, 1'b0}, got);
        @(negedge clk);
        chk("R2 no irq on mismatch", {7'd0, irq}, 8'd0);
        chk("R2 no stretch on mismatch", {7'd0, scl_pull}, 8'd0);
        put_bit(1'b1, g);
        chk("R2 no ack on mismatch", {7'd0, g}, 8'd1);
        send_byte(8'h00, got);
        @(negedge clk);
        chk("R2 still silent", {6'd0, irq, scl_pull}, 8'd0);
        bus_stop();
    endtask

    task automatic t_no_stretch();
        logic [7:0] got;
        logic g;
        stretch_off = 1'b1;
        bus_start();
        send_byte(8'hB4, got);
        @(negedge clk);
        chk("R7 irq without stretch", {7'd0, irq}, 8'd1);
        chk("R7 no scl hold", {7'd0, scl_pull}, 8'd0);
        put_bit(1'b1, g);
        chk("R9 sda released without write", {7'd0, g}, 8'd1);
        chk("R10 nack sampled", {7'd0, ack_nack}, 8'd1);
        bus_stop();
        @(negedge clk);
        chk("R11 stop clears irq", {7'd0, irq}, 8'd0);
        stretch_off = 1'b0;
    endtask

    task automatic t_read_from_slave();
        logic [7:0] got;
        logic g;
        count_single = 1'b1;
        bus_start();
        put_bit(1'b1, g);
        @(negedge clk);
        chk("R2 single mode ignored in address", {7'd0, irq}, 8'd0);
        for (int i = 6; i >= 0; i--) begin
            logic gb;
            put_bit(i == 0 ? 1'b1 : ((7'h5A >> (i - 1)) & 7'h01) != 0, gb);
        end
        @(negedge clk);
        chk("R2 irq after full address", {7'd0, irq}, 8'd1);
        chk("R3 read address byte", rd_data, 8'hB5);
        fw_write(8'h7F);
        put_bit(1'b1, g);
        chk("R6 address ack", {7'd0, g}, 8'd0);
        @(negedge clk);
        chk("R4 irq per bit", {7'd0, irq}, 8'd1);
        count_single = 1'b0;
        fw_write(8'hA5);
        send_byte(8'hFF, got);
        chk("R8 transmitted byte", got, 8'hA5);
        @(negedge clk);
        chk("R3 irq after sent byte", {7'd0, irq}, 8'd1);
        chk("R5 stretch after sent byte", {7'd0, scl_pull}, 8'd1);
        count_single = 1'b1;
        fw_write(8'hFF);
        put_bit(1'b1, g);
        @(negedge clk);
        chk("R10 master nack read", {7'd0, ack_nack}, 8'd1);
        chk("R4 irq on nack bit", {7'd0, irq}, 8'd1);
        count_single = 1'b0;
        fw_write(8'hFF);
        bus_stop();
    endtask

    task automatic t_start_clears();
        logic [7:0] got;
        logic g;
        bus_start();
        for (int i = 7; i >= 1; i--) begin
            logic gb;
            put_bit(((8'hB5 >> i) & 8'h01) != 0, gb);
        end
        m_sda = 1'b1; idle(H);
        m_scl = 1'b1; idle(H);
        @(negedge clk);
        chk("R11 irq armed before start", {7'd0, irq}, 8'd1);
        m_sda = 1'b0; idle(H);
        @(negedge clk);
        chk("R11 start clears irq", {7'd0, irq}, 8'd0);
        m_scl = 1'b0; idle(H + 8);
        @(negedge clk);
        chk("R11 start cancels stretch", {7'd0, scl_pull}, 8'd0);
        send_byte(8'hB4, got);
        @(negedge clk);
        chk("R11 new address phase", {7'd0, irq}, 8'd1);
        fw_write(8'hFF);
        put_bit(1'b1, g);
        bus_stop();
    endtask

    initial begin
        idle(150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(5);
        @(negedge clk) rst_n = 1'b1;
        idle(4);
        t_reset();
        t_write_to_slave();
        t_mismatch();
        t_no_stretch();
        t_read_from_slave();
        t_start_clears();
        idle(10);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule